// File: doc/BRIEF.md
# Partial Transfer Report Queue

This block sits beside a transfer engine whose streaming source may end a transfer before the programmed byte count is reached. Each time a transfer completes, the engine presents one completion event. The event carries the transfer ID, the number of bytes actually moved, the programmed byte count, and a flag that says whether a short transfer should be reported. When that flag is set and the transfer came up short, the block queues the ID and the actual byte count in a small first-in first-out store.

Software drains the queue through three read-only register views. A length view shows the byte count at the head. An ID view shows the ID at the head and releases that entry. A status view holds a pending flag in bit 31 and a sticky overflow flag in bit 30. The expected loop is: read the length, read the ID, test bit 31, and repeat while bit 31 is set. Software computes the residue as the programmed total minus the reported count, so the block holds no residue logic.

Top module: `partial_report_fifo`

## Requirements
- R1: An event is queued only when `evtValid` and `evtReportEn` are both high and `evtActualLen` is strictly less than `evtProgLen`. Any other event leaves the queue unchanged.
- R2: An event whose actual count equals or exceeds the programmed count is not queued, even with reporting enabled.
- R3: A read with `rdSel` = 0 (length view) returns the head entry's actual byte count, zero-extended in bits LENW-1:0. It has no side effect.
- R4: A read with `rdSel` = 1 (ID view) returns the head entry's ID, zero-extended in bits IDW-1:0. It removes that entry at the end of the read cycle.
- R5: Entries leave the queue in the order they were queued.
- R6: A read with `rdSel` = 2 (status view) returns bit 31 = 1 while at least one entry is queued and 0 otherwise. All bits other than 31 and 30 read as zero.
- R7: A qualifying event that arrives while DEPTH entries are queued, with no removal in the same cycle, is discarded. It sets status bit 30, which then stays set until reset.
- R8: A read of the length or ID view with the queue empty returns zero and changes no state. The same holds for any read with `rdSel` = 3, which always returns zero.
- R9: After reset the queue is empty, and status bits 31 and 30 are both zero.
- R10: When a qualifying event and an ID-view read fall in the same cycle with the queue full, the head is removed, the new entry is queued, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Completion event strobe, one cycle per completion |
| evtId | input | IDW | ID of the completed transfer |
| evtActualLen | input | LENW | Bytes actually moved |
| evtProgLen | input | LENW | Bytes programmed |
| evtReportEn | input | 1 | Short-transfer reporting requested for this transfer |
| rdEn | input | 1 | Register read strobe |
| rdSel | input | 2 | Register view: 0 length, 1 ID (removes head), 2 status, 3 reserved |
| rdData | output | DATAW | Read data, valid in the same cycle as `rdEn` |

## Verification
The embedded properties check the following on every cycle:
- The occupancy never exceeds the depth.
- A non-qualifying event, or a read of an empty queue, leaves the occupancy unchanged.
- An event that meets a full queue raises the overflow flag.
- The overflow flag never clears.
- The read and write positions advance whenever an entry is removed or added.

Only the directed scenarios can show the rest. These cover the values returned by each register view, first-in first-out order across several entries, the exact content that survives a drop, and the same-cycle add-and-remove at full depth.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam logic [1:0] SEL_LEN  = 2'd0;
  localparam logic [1:0] SEL_ID   = 2'd1;
  localparam logic [1:0] SEL_DONE = 2'd2;

  typedef struct packed {
    logic push;
    logic pop;
    logic empty;
    logic overflow;
  } prt_strobe_t;
endpackage

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LENW  = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evtValid,
  input  logic            evtReportEn,
  input  logic [LENW-1:0] evtActualLen,
  input  logic [LENW-1:0] evtProgLen,
  input  logic            rdEn,
  input  logic [1:0]      rdSel,
  output prt_strobe_t     strb
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] CAP = CNTW'(DEPTH);

  logic [CNTW-1:0] count;
  logic overflow;
  logic qualify, popReq, atCap, pushOk, dropEvt;

  assign qualify = evtValid && evtReportEn && (evtActualLen < evtProgLen);
  assign popReq  = rdEn && (rdSel == SEL_ID) && (count != '0);
  assign atCap   = (count == CAP);
  assign pushOk  = qualify && (!atCap || popReq);
  assign dropEvt = qualify && atCap && !popReq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pushOk && !popReq)      count <= count + 1'b1;
      else if (!pushOk && popReq) count <= count - 1'b1;
      if (dropEvt) overflow <= 1'b1;
    end
  end

  always_comb begin
    strb.push     = pushOk;
    strb.pop      = popReq;
    strb.empty    = (count == '0);
    strb.overflow = overflow;
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  // R7
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qualify && atCap && !popReq) |=> (overflow && count == CAP));

  // R7
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R1
  ignore_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qualify && !popReq) |=> $stable(count));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && count == '0 && !qualify) |=> (count == '0));
endmodule

// File: rtl/prt_data.sv
module prt_data
  import prt_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDW   = 5,
  parameter int LENW  = 24,
  parameter int DATAW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDW-1:0]   evtId,
  input  logic [LENW-1:0]  evtActualLen,
  input  logic [1:0]       rdSel,
  input  prt_strobe_t      strb,
  output logic [DATAW-1:0] rdData
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

  logic [IDW-1:0]  idMem  [DEPTH];
  logic [LENW-1:0] lenMem [DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.push && wrPtr == PTRW'(i)) begin
        idMem[i]  <= evtId;
        lenMem[i] <= evtActualLen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_LEN:  if (!strb.empty) rdData[LENW-1:0] = lenMem[rdPtr];
      SEL_ID:   if (!strb.empty) rdData[IDW-1:0]  = idMem[rdPtr];
      SEL_DONE: begin
        rdData[DATAW-1] = !strb.empty;
        rdData[DATAW-2] = strb.overflow;
      end
      default:  rdData = '0;
    endcase
  end

  // R5
  pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |=> (rdPtr != $past(rdPtr)));

  // R5
  push_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.push |=> (wrPtr != $past(wrPtr)));
endmodule

// File: rtl/partial_report_fifo.sv
module partial_report_fifo
  import prt_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDW   = 5,
  parameter int LENW  = 24,
  parameter int DATAW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evtValid,
  input  logic [IDW-1:0]   evtId,
  input  logic [LENW-1:0]  evtActualLen,
  input  logic [LENW-1:0]  evtProgLen,
  input  logic             evtReportEn,
  input  logic             rdEn,
  input  logic [1:0]       rdSel,
  output logic [DATAW-1:0] rdData
);
  prt_strobe_t strb;

  prt_ctrl #(.DEPTH(DEPTH), .LENW(LENW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtReportEn(evtReportEn),
    .evtActualLen(evtActualLen), .evtProgLen(evtProgLen),
    .rdEn(rdEn), .rdSel(rdSel), .strb(strb)
  );

  prt_data #(.DEPTH(DEPTH), .IDW(IDW), .LENW(LENW), .DATAW(DATAW)) u_data (
    .clk(clk), .rst_n(rst_n), .evtId(evtId), .evtActualLen(evtActualLen),
    .rdSel(rdSel), .strb(strb), .rdData(rdData)
  );
endmodule

// File: tb/partial_report_fifo_test.sv
module partial_report_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evtValid = 1'b0;
  logic [4:0]  evtId = '0;
  logic [23:0] evtActualLen = '0;
  logic [23:0] evtProgLen = '0;
  logic        evtReportEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdSel = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [31:0] PEND = 32'h8000_0000;
  localparam logic [31:0] OVF  = 32'h4000_0000;

  always #2 clk = ~clk;

  partial_report_fifo uut (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtId(evtId),
    .evtActualLen(evtActualLen), .evtProgLen(evtProgLen),
    .evtReportEn(evtReportEn), .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pushEvt(input logic [4:0] id, input int act, input int prog, input bit en);
    @(negedge clk);
    evtValid = 1'b1; evtId = id; evtActualLen = 24'(act);
    evtProgLen = 24'(prog); evtReportEn = en;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdSel = sel;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic drainOne(input string req, input logic [4:0] id, input int len);
    logic [31:0] v;
    readReg(2'd0, v); chk(req, v, 32'(len));
    readReg(2'd1, v); chk(req, v, 32'(id));
  endtask

  task automatic testReset();
    logic [31:0] v;
    readReg(2'd2, v); chk("R9 status after reset", v, 32'h0);
    readReg(2'd0, v); chk("R8 empty length read", v, 32'h0);
    readReg(2'd1, v); chk("R8 empty id read", v, 32'h0);
    readReg(2'd3, v); chk("R8 reserved view", v, 32'h0);
    readReg(2'd2, v); chk("R8 status unchanged after empty reads", v, 32'h0);
  endtask

  task automatic testQualify();
    logic [31:0] v;
    pushEvt(5'd3, 100, 200, 1'b0);
    readReg(2'd2, v); chk("R1 report disabled not queued", v, 32'h0);
    pushEvt(5'd4, 200, 200, 1'b1);
    readReg(2'd2, v); chk("R2 equal length not queued", v, 32'h0);
    pushEvt(5'd5, 300, 200, 1'b1);
    readReg(2'd2, v); chk("R2 longer length not queued", v, 32'h0);
    pushEvt(5'd6, 199, 200, 1'b1);
    readReg(2'd2, v); chk("R1 R6 short transfer pending", v, PEND);
  endtask

  task automatic testReadViews();
    logic [31:0] v;
    readReg(2'd0, v); chk("R3 length view", v, 32'd199);
    readReg(2'd0, v); chk("R3 length read has no side effect", v, 32'd199);
    readReg(2'd1, v); chk("R4 id view", v, 32'd6);
    readReg(2'd2, v); chk("R4 R6 id read pops, pending clear", v, 32'h0);
  endtask

  task automatic testOrder();
    logic [31:0] v;
    pushEvt(5'd17, 24'h123456, 24'hFFFFFF, 1'b1);
    pushEvt(5'd31, 0, 64, 1'b1);
    pushEvt(5'd2, 1000, 4096, 1'b1);
    drainOne("R5 order first", 5'd17, 24'h123456);
    readReg(2'd2, v); chk("R6 pending with entries left", v, PEND);
    drainOne("R5 order second", 5'd31, 0);
    drainOne("R5 order third", 5'd2, 1000);
    readReg(2'd2, v); chk("R6 pending clear after drain", v, 32'h0);
  endtask

  task automatic testSimultaneous();
    logic [31:0] v;
    for (int i = 1; i <= 4; i++) pushEvt(5'(i), 10 * i, 1000, 1'b1);
    @(negedge clk);
    evtValid = 1'b1; evtId = 5'd5; evtActualLen = 24'd50; evtProgLen = 24'd1000;
    evtReportEn = 1'b1; rdEn = 1'b1; rdSel = 2'd1;
    #1 v = rdData;
    chk("R10 head id during concurrent pop", v, 32'd1);
    @(negedge clk);
    evtValid = 1'b0; rdEn = 1'b0;
    readReg(2'd2, v); chk("R10 no overflow on concurrent push/pop", v, PEND);
    for (int i = 2; i <= 5; i++) drainOne("R10 contents after concurrent", 5'(i), 10 * i);
    readReg(2'd2, v); chk("R10 empty after drain", v, 32'h0);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) pushEvt(5'(20 + i), 7 + i, 100, 1'b1);
    readReg(2'd2, v); chk("R7 full, no overflow yet", v, PEND);
    pushEvt(5'd9, 1, 100, 1'b1);
    readReg(2'd2, v); chk("R7 overflow flagged on drop", v, PEND | OVF);
    for (int i = 0; i < 4; i++) drainOne("R7 retained entries", 5'(20 + i), 7 + i);
    readReg(2'd2, v); chk("R7 dropped entry absent, overflow sticky", v, OVF);
    readReg(2'd1, v); chk("R8 empty id read after drain", v, 32'h0);
    readReg(2'd2, v); chk("R8 R7 state unchanged by empty read", v, OVF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testQualify();
    testReadViews();
    testOrder();
    testSimultaneous();
    testOverflow();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule